// File: doc/BRIEF.md
# Selectable-source countdown timer

This block is an 8-bit down-counter for a real-time clock. Its pace comes from one of four slow tick enables that are generated elsewhere from the fast system clock. The four rates are 4096 Hz, 64 Hz, 1 Hz and one tick per minute. A control register holds a run bit and a two-bit source code. A second register holds the countdown value. Writing it loads both the live count and a reload copy.

While the block runs, each tick of the selected source lowers the count by one. On the step from 1 to 0 the block sets a sticky expiry flag and reloads the last written value, so the countdown repeats. The repeat period is therefore n ticks, which is n divided by the source frequency. An interrupt output follows the flag, gated by an external interrupt-enable bit. Software clears the flag with a dedicated clear strobe, which models writing 0 to the flag.

All state lives in the system clock domain, so the count can be read back directly. The reset source code is the once-per-minute rate, which is the lowest-activity setting.

Top module: `rtc_countdown_timer`

## Requirements
- R1: After reset the count and the reload value are 0x00, the flag and interrupt are 0, and the control readback is 0x03 (run bit 0, source code 11).
- R2: A control write stores bit 7 as the run bit and bits 1:0 as the source code. The control readback is {run, 5'b00000, code}, so bits 6:2 always read 0.
- R3: A countdown write loads the live count and the reload value with the written byte, whether or not the timer runs. The new value is readable on the cycle after the write edge.
- R4: With the run bit at 0, tick enables leave the count unchanged.
- R5: With the run bit at 1, only the tick enable with index equal to the source code affects the count. tickEn[0] is 4096 Hz (code 00), tickEn[1] is 64 Hz (code 01), tickEn[2] is 1 Hz (code 10) and tickEn[3] is 1/60 Hz (code 11).
- R6: A selected tick at a count above 1 lowers the count by one. A selected tick at count 1 reloads the last written value and sets the flag, so expiry comes every n selected ticks.
- R7: With a count of 0 the timer does not count and never sets the flag.
- R8: The flag stays set until the clear strobe. If an expiry and the clear strobe fall in the same cycle, the flag ends up set.
- R9: The interrupt output is 1 exactly when the flag is 1 and the interrupt-enable input is 1.
- R10: A countdown write in the same cycle as a selected tick wins: the count takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWrEn | input | 1 | Write strobe for the control register |
| ctrlWrData | input | 8 | Control write data (bit 7 run, bits 1:0 source code) |
| cntWrEn | input | 1 | Write strobe for the countdown register |
| cntWrData | input | 8 | Countdown write data |
| flagClr | input | 1 | Clears the expiry flag |
| intEnable | input | 1 | Interrupt enable for the expiry flag |
| tickEn | input | 4 | One-cycle tick enables, indexed by source code |
| ctrlRd | output | 8 | Control register readback |
| cntRd | output | 8 | Live count readback |
| timerFlag | output | 1 | Sticky expiry flag |
| timerIrq | output | 1 | Interrupt request |

## Verification
Register writes, ticks and flag clears all act on the clock edge that samples them. Their results on cntRd, ctrlRd and timerFlag are due one edge later. timerIrq follows the flag and intEnable with no extra register. The bench drives each stimulus on a falling edge and holds it for one cycle. It then checks on the next falling edge, after exactly one rising edge has passed. Same-cycle collisions are driven together in a single cycle, and tick counts to expiry are stepped one pulse at a time.

// File: rtl/rtc_timer_pkg.sv
package rtc_timer_pkg;
  parameter int CNT_W = 8;
  parameter int SEL_W = 2;
  localparam int NUM_SRC = 1 << SEL_W;

  typedef struct packed {
    logic load;
    logic decrement;
    logic expire;
  } timerStrobes_t;
endpackage

// File: rtl/rtc_timer_ctrl.sv
module rtc_timer_ctrl
  import rtc_timer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWrEn,
  input  logic [DATA_W-1:0]  ctrlWrData,
  input  logic               cntWrEn,
  input  logic [NUM_SRC-1:0] tickEn,
  input  logic               countIsZero,
  input  logic               countIsOne,
  output logic [DATA_W-1:0]  ctrlRd,
  output timerStrobes_t      strobes
);
  logic             runBit;
  logic [SEL_W-1:0] srcSel;
  logic             selTick;
  logic             stepNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit <= 1'b0;
      srcSel <= '1;
    end else if (ctrlWrEn) begin
      runBit <= ctrlWrData[DATA_W-1];
      srcSel <= ctrlWrData[SEL_W-1:0];
    end
  end

  always_comb begin
    ctrlRd = '0;
    ctrlRd[DATA_W-1] = runBit;
    ctrlRd[SEL_W-1:0] = srcSel;
  end

  assign selTick = tickEn[srcSel];
  assign stepNow = runBit && selTick && !cntWrEn && !countIsZero;

  always_comb begin
    strobes.load      = cntWrEn;
    strobes.decrement = stepNow && !countIsOne;
    strobes.expire    = stepNow && countIsOne;
  end
endmodule

// File: rtl/rtc_timer_dp.sv
module rtc_timer_dp
  import rtc_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  timerStrobes_t    strobes,
  input  logic [CNT_W-1:0] loadValue,
  input  logic             flagClr,
  output logic [CNT_W-1:0] count,
  output logic             countIsZero,
  output logic             countIsOne,
  output logic             flag
);
  logic [CNT_W-1:0] reloadVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      reloadVal <= '0;
    end else if (strobes.load) begin
      count     <= loadValue;
      reloadVal <= loadValue;
    end else if (strobes.expire) begin
      count <= reloadVal;
    end else if (strobes.decrement) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               flag <= 1'b0;
    else if (strobes.expire) flag <= 1'b1;
    else if (flagClr)        flag <= 1'b0;
  end

  assign countIsZero = (count == '0);
  assign countIsOne  = (count == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/rtc_countdown_timer.sv
module rtc_countdown_timer
  import rtc_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWrEn,
  input  logic [CNT_W-1:0]   ctrlWrData,
  input  logic               cntWrEn,
  input  logic [CNT_W-1:0]   cntWrData,
  input  logic               flagClr,
  input  logic               intEnable,
  input  logic [NUM_SRC-1:0] tickEn,
  output logic [CNT_W-1:0]   ctrlRd,
  output logic [CNT_W-1:0]   cntRd,
  output logic               timerFlag,
  output logic               timerIrq
);
  timerStrobes_t strobes;
  logic          countIsZero;
  logic          countIsOne;

  rtc_timer_ctrl #(.DATA_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .cntWrEn(cntWrEn), .tickEn(tickEn), .countIsZero(countIsZero),
    .countIsOne(countIsOne), .ctrlRd(ctrlRd), .strobes(strobes)
  );

  rtc_timer_dp dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadValue(cntWrData),
    .flagClr(flagClr), .count(cntRd), .countIsZero(countIsZero),
    .countIsOne(countIsOne), .flag(timerFlag)
  );

  assign timerIrq = timerFlag & intEnable;
endmodule

// File: rtl/rtc_timer_chk.sv
module rtc_timer_chk
  import rtc_timer_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cntWrEn,
  input logic             flagClr,
  input logic             intEnable,
  input logic [CNT_W-1:0] ctrlRd,
  input logic [CNT_W-1:0] cntRd,
  input logic             timerFlag,
  input logic             timerIrq
);
  assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlRd[CNT_W-1] && !cntWrEn) |=> $stable(cntRd));

  assert_zero_stays_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cntRd == '0 && !cntWrEn) |=> (cntRd == '0));

  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWrEn && cntRd > 1) |=> (cntRd == $past(cntRd) || cntRd == $past(cntRd) - 1'b1));

  assert_flag_from_one_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerFlag) |-> ($past(cntRd) == 1));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (timerFlag && !flagClr) |=> timerFlag);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |-> !timerIrq);
endmodule

bind rtc_countdown_timer rtc_timer_chk chk_i (
  .clk(clk), .rstN(rstN), .cntWrEn(cntWrEn), .flagClr(flagClr),
  .intEnable(intEnable), .ctrlRd(ctrlRd), .cntRd(cntRd),
  .timerFlag(timerFlag), .timerIrq(timerIrq)
);

// File: tb/rtc_countdown_timer_tb_top.sv
`timescale 1ns/1ps
module rtc_countdown_timer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = '0;
  logic       cntWrEn = 1'b0;
  logic [7:0] cntWrData = '0;
  logic       flagClr = 1'b0;
  logic       intEnable = 1'b0;
  logic [3:0] tickEn = '0;
  logic [7:0] ctrlRd, cntRd;
  logic       timerFlag, timerIrq;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rtc_countdown_timer dut_i (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, release and sample at the next
  task automatic cyc(logic [3:0] t, logic clr, logic cw, logic [7:0] cd);
    tickEn = t; flagClr = clr; cntWrEn = cw; cntWrData = cd;
    @(negedge clk);
    tickEn = '0; flagClr = 0; cntWrEn = 0;
  endtask

  task automatic wrCtrl(logic [7:0] d);
    ctrlWrEn = 1; ctrlWrData = d;
    @(negedge clk);
    ctrlWrEn = 0;
  endtask

  task automatic testReset();
    chk("R1 count", cntRd, 0);
    chk("R1 ctrl", ctrlRd, 8'h03);
    chk("R1 flag", timerFlag, 0);
    chk("R1 irq", timerIrq, 0);
  endtask

  task automatic testCtrl();
    wrCtrl(8'hFF); chk("R2 ctrl all ones", ctrlRd, 8'h83);
    wrCtrl(8'h01); chk("R2 ctrl code 01", ctrlRd, 8'h01);
  endtask

  task automatic testStopped();
    wrCtrl(8'h00);
    cyc(0, 0, 1, 8'd5); chk("R3 load while stopped", cntRd, 5);
    cyc(4'hF, 0, 0, 0); cyc(4'h1, 0, 0, 0);
    chk("R4 ticks ignored when stopped", cntRd, 5);
  endtask

  task automatic testSelect();
    wrCtrl(8'h81);
    cyc(4'b1101, 0, 0, 0); chk("R5 unselected ticks code 01", cntRd, 5);
    cyc(4'b0010, 0, 0, 0); chk("R5 64Hz tick code 01", cntRd, 4);
    wrCtrl(8'h83);
    cyc(4'b0111, 0, 0, 0); chk("R5 unselected ticks code 11", cntRd, 4);
    cyc(4'b1000, 0, 0, 0); chk("R5 minute tick code 11", cntRd, 3);
    wrCtrl(8'h82);
    cyc(4'b0100, 0, 0, 0); chk("R5 1Hz tick code 10", cntRd, 2);
  endtask

  task automatic testExpire();
    wrCtrl(8'h80);
    cyc(0, 0, 1, 8'd3);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    chk("R6 count before expiry", cntRd, 1);
    chk("R6 flag before expiry", timerFlag, 0);
    cyc(1, 0, 0, 0);
    chk("R6 reload on expiry", cntRd, 3);
    chk("R6 flag on expiry", timerFlag, 1);
    intEnable = 0; #1; chk("R9 irq masked", timerIrq, 0);
    intEnable = 1; #1; chk("R9 irq enabled", timerIrq, 1);
  endtask

  task automatic testSticky();
    cyc(1, 0, 0, 0); chk("R8 flag sticky", timerFlag, 1);
    cyc(0, 1, 0, 0); chk("R8 flag cleared", timerFlag, 0);
    chk("R9 irq follows clear", timerIrq, 0);
    cyc(1, 0, 0, 0); chk("R6 count before collision", cntRd, 1);
    cyc(1, 1, 0, 0); chk("R8 expiry beats clear", timerFlag, 1);
    chk("R6 second period reload", cntRd, 3);
    cyc(0, 1, 0, 0);
  endtask

  task automatic testZero();
    cyc(0, 0, 1, 8'd0);
    for (int i = 0; i < 5; i++) cyc(4'hF, 0, 0, 0);
    chk("R7 zero count holds", cntRd, 0);
    chk("R7 zero sets no flag", timerFlag, 0);
  endtask

  task automatic testPriority();
    cyc(0, 0, 1, 8'd5);
    cyc(1, 0, 1, 8'd9); chk("R10 write beats tick", cntRd, 9);
    cyc(1, 0, 0, 0);  chk("R3 write updates reload path", cntRd, 8);
    cyc(0, 0, 1, 8'd1);
    cyc(1, 0, 0, 0);  chk("R6 reload of 1 repeats", cntRd, 1);
    chk("R6 flag with n=1", timerFlag, 1);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testCtrl();
    testStopped();
    testSelect();
    testExpire();
    testSticky();
    testZero();
    testPriority();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule